// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block executes a single decision step of the 1-Wire ROM search in hardware. A one-cycle start pulse arrives together with a preferred branch direction. The engine then asks a lower bit-slot layer for two read slots (the address bit and its inverted copy), works out which branch to follow, and asks the same layer for one write slot carrying that branch bit. When the step ends it raises a one-clock done strobe and holds a 3-bit outcome code.

The bit-slot layer is reached through a request/acknowledge pair. The engine raises `slot_req_o` together with the operation type and holds them until one `slot_ack_i` pulse, which also carries the read value. Slot timing and the 64-step outer loop stay outside this block. If the slot layer stays silent for too long, the step is abandoned and an error flag is raised.

Top module: `owb_triplet_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `slot_req_o`, `slot_wr_o`, `err_o` are 0 and `result_o` is 3'b000.
- R2: An accepted step issues, in order, a read slot (`slot_wr_o`=0) for the address bit, a read slot for the inverted bit, then a write slot (`slot_wr_o`=1). Each request is held with its type unchanged until it is acknowledged. With a slot layer acknowledging after L+2 cycles of request, a full step keeps `slot_req_o` high for 3*(L+2) cycles.
- R3: If both sampled bits are 1 (nobody answered), the result is 3'b011 and no write slot is issued.
- R4: If both sampled bits are 0 (conflict), the preferred direction is followed: the result is 3'b100 for preference 1 and 3'b000 for preference 0.
- R5: If exactly one sampled bit is 1, the direction is the address bit: the result is 3'b101 when the address bit is 1 and 3'b010 when it is 0.
- R6: Only bit 0 of `slot_rdata_i` is used as the sampled bit; the upper bits have no effect.
- R7: Result encoding is bit 0 = address bit, bit 1 = inverted bit, bit 2 = direction; the bit sent in the write slot (`slot_wbit_o`) equals result bit 2.
- R8: If any request stays unacknowledged for ACK_WAIT cycles, the step ends with no further slots, `result_o`=3'b011 and `err_o`=1; on the first slot `slot_req_o` is high for exactly ACK_WAIT cycles.
- R9: A start pulse while `busy_o` is high is ignored: it neither restarts nor changes the running step, and no extra step follows.
- R10: `done_o` is high for exactly one clock per step, and `busy_o` is low on the following clock; `result_o` and `err_o` hold until the next accepted start.
- R11: An accepted start clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one search step (taken only when idle) |
| dir_pref_i | input | 1 | Preferred direction used on a conflict |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-clock end-of-step strobe |
| result_o | output | 3 | Outcome code {direction, inverted bit, address bit} |
| err_o | output | 1 | Slot layer did not acknowledge in time |
| slot_req_o | output | 1 | Request to the bit-slot layer |
| slot_wr_o | output | 1 | Request type: 1 write slot, 0 read slot |
| slot_wbit_o | output | 1 | Bit to send in a write slot |
| slot_ack_i | input | 1 | One-cycle acknowledge from the bit-slot layer |
| slot_rdata_i | input | RDATA_W | Read value, valid with the acknowledge |

## Verification
The bench builds the engine with ACK_WAIT = 12 and RDATA_W = 8. The short acknowledge window lets the abort be provoked in each of the three slots, and the exact request-high count on the first slot is measured against it within a few dozen cycles. The eight-bit read word lets the slot model place opposite values in the upper bits to show that only bit 0 counts.

// File: rtl/owb_trip_pkg.sv
package owb_trip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_INV,
    ST_WR_DIR,
    ST_FINISH
  } trip_state_e;

  localparam logic [2:0] CODE_NOBODY = 3'b011;

  // nobody answered: both the bit and its complement float high
  function automatic logic nobody_home(input logic a_bit, input logic i_bit);
    return a_bit & i_bit;
  endfunction

  // branch choice: on agreement of the two reads (conflict) take the preference,
  // otherwise follow the address bit
  function automatic logic pick_branch(input logic a_bit, input logic i_bit,
                                       input logic pref);
    return (a_bit == i_bit) ? pref : a_bit;
  endfunction

  function automatic logic [2:0] pack_code(input logic a_bit, input logic i_bit,
                                           input logic pref);
    if (nobody_home(a_bit, i_bit)) return CODE_NOBODY;
    return {pick_branch(a_bit, i_bit, pref), i_bit, a_bit};
  endfunction

endpackage

// File: rtl/owb_trip_decide.sv
module owb_trip_decide
  import owb_trip_pkg::*;
(
  input  logic       addr_bit,
  input  logic       inv_bit,
  input  logic       pref,
  output logic       branch,
  output logic       empty,
  output logic [2:0] code
);

  always_comb begin
    empty  = nobody_home(addr_bit, inv_bit);
    branch = pick_branch(addr_bit, inv_bit, pref);
    code   = pack_code(addr_bit, inv_bit, pref);
  end

  always_comb begin
    if (!empty) a_r7_code_dir : assert (code[2] == branch);
    if (empty)  a_r3_code_nobody : assert (code == CODE_NOBODY);
  end

endmodule

// File: rtl/owb_trip_ackwait.sv
module owb_trip_ackwait #(
  parameter int ACK_WAIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic ack,
  output logic expired
);

  localparam int CW = $clog2(ACK_WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_WAIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!waiting || ack) cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = waiting && !ack && (cnt_q == LAST);

  a_r8_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r8_idle_clear : assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |=> (cnt_q == '0));

endmodule

// File: rtl/owb_trip_seq.sv
module owb_trip_seq
  import owb_trip_pkg::*;
#(
  parameter int RDATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dir_pref_i,
  input  logic               slot_ack_i,
  input  logic [RDATA_W-1:0] slot_rdata_i,
  input  logic               expired,
  input  logic               dec_branch,
  input  logic               dec_empty,
  input  logic [2:0]         dec_code,
  output logic               addr_q,
  output logic               pref_q,
  output logic               sample_bit,
  output logic               busy_o,
  output logic               done_o,
  output logic [2:0]         result_o,
  output logic               err_o,
  output logic               slot_req_o,
  output logic               slot_wr_o,
  output logic               slot_wbit_o
);

  trip_state_e st_q, st_d;
  logic        dir_q;
  logic [2:0]  res_q;
  logic        err_q;

  // named events
  logic ev_accept, ev_addr_cap, ev_inv_cap, ev_wr_done, ev_abort;

  assign sample_bit  = slot_rdata_i[0];
  assign slot_req_o  = (st_q == ST_RD_ADDR) || (st_q == ST_RD_INV) || (st_q == ST_WR_DIR);
  assign slot_wr_o   = (st_q == ST_WR_DIR);
  assign slot_wbit_o = (st_q == ST_WR_DIR) & dir_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FINISH);
  assign result_o    = res_q;
  assign err_o       = err_q;

  assign ev_accept   = (st_q == ST_IDLE) && start_i;
  assign ev_abort    = slot_req_o && expired;
  assign ev_addr_cap = (st_q == ST_RD_ADDR) && slot_ack_i;
  assign ev_inv_cap  = (st_q == ST_RD_INV) && slot_ack_i;
  assign ev_wr_done  = (st_q == ST_WR_DIR) && slot_ack_i;

  always_comb begin
    st_d = st_q;
    if (ev_abort) st_d = ST_FINISH;
    else begin
      unique case (st_q)
        ST_IDLE:    if (start_i) st_d = ST_RD_ADDR;
        ST_RD_ADDR: if (slot_ack_i) st_d = ST_RD_INV;
        ST_RD_INV:  if (slot_ack_i) st_d = dec_empty ? ST_FINISH : ST_WR_DIR;
        ST_WR_DIR:  if (slot_ack_i) st_d = ST_FINISH;
        ST_FINISH:  st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= 1'b0;
      pref_q <= 1'b0;
      dir_q  <= 1'b0;
      res_q  <= 3'b000;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_accept) begin
        pref_q <= dir_pref_i;
        err_q  <= 1'b0;
        res_q  <= 3'b000;
      end
      if (ev_abort) begin
        res_q <= CODE_NOBODY;
        err_q <= 1'b1;
      end else begin
        if (ev_addr_cap) addr_q <= sample_bit;
        if (ev_inv_cap) begin
          dir_q <= dec_branch;
          res_q <= dec_code;
        end
      end
    end
  end

  a_r2_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_ack_i && !expired) |=> (slot_req_o && $stable(slot_wr_o)));

  a_r2_write_last : assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_done |=> !slot_req_o);

  a_r3_no_write : assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inv_cap && dec_empty) |=> !slot_req_o);

  a_r8_abort_end : assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (done_o && err_o && (result_o == CODE_NOBODY)));

  a_r9_start_only_idle : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r10_done_single : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r10_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(err_o)));

endmodule

// File: rtl/owb_triplet_engine.sv
module owb_triplet_engine #(
  parameter int ACK_WAIT = 1000,
  parameter int RDATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dir_pref_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2:0]         result_o,
  output logic               err_o,
  output logic               slot_req_o,
  output logic               slot_wr_o,
  output logic               slot_wbit_o,
  input  logic               slot_ack_i,
  input  logic [RDATA_W-1:0] slot_rdata_i
);

  logic       expired;
  logic       dec_branch, dec_empty;
  logic [2:0] dec_code;
  logic       addr_q, pref_q, sample_bit;

  owb_trip_seq #(.RDATA_W(RDATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dir_pref_i   (dir_pref_i),
    .slot_ack_i   (slot_ack_i),
    .slot_rdata_i (slot_rdata_i),
    .expired      (expired),
    .dec_branch   (dec_branch),
    .dec_empty    (dec_empty),
    .dec_code     (dec_code),
    .addr_q       (addr_q),
    .pref_q       (pref_q),
    .sample_bit   (sample_bit),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .err_o        (err_o),
    .slot_req_o   (slot_req_o),
    .slot_wr_o    (slot_wr_o),
    .slot_wbit_o  (slot_wbit_o)
  );

  owb_trip_decide u_dec (
    .addr_bit (addr_q),
    .inv_bit  (sample_bit),
    .pref     (pref_q),
    .branch   (dec_branch),
    .empty    (dec_empty),
    .code     (dec_code)
  );

  owb_trip_ackwait #(.ACK_WAIT(ACK_WAIT)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (slot_req_o),
    .ack     (slot_ack_i),
    .expired (expired)
  );

  a_r7_wbit_matches : assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && (result_o != 3'b011)) |-> ($past(slot_wbit_o) == result_o[2]));

endmodule

// File: tb/owb_triplet_engine_test.sv
module owb_triplet_engine_test;

  localparam int AW  = 12;
  localparam int RW  = 8;
  localparam int LAT = 2;
  localparam int SLOT = LAT + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          dir_pref_i = 1'b0;
  logic          busy_o, done_o, err_o;
  logic [2:0]    result_o;
  logic          slot_req_o, slot_wr_o, slot_wbit_o;
  logic          slot_ack_i;
  logic [RW-1:0] slot_rdata_i;

  int total = 0;
  int bad = 0;

  // slot layer model configuration (written by tasks only)
  int          arm_id = 0;
  int          ack_budget = 3;
  logic [RW-1:0] rd_word0 = '0, rd_word1 = '0;

  // slot layer model state
  int seen_arm = 0;
  int given = 0;
  int rd_idx = 0;
  int lat_cnt = 0;

  // monitor counters
  int mon_arm = 0;
  int req_cyc = 0, xfers = 0, writes = 0, done_cyc = 0;
  logic last_wbit = 1'b0;
  logic [1:0] order_ok = 2'b11;
  int rd_seen = 0;

  always #10 clk = ~clk;

  owb_triplet_engine #(.ACK_WAIT(AW), .RDATA_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_pref_i(dir_pref_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o),
    .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o),
    .slot_ack_i(slot_ack_i), .slot_rdata_i(slot_rdata_i)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      slot_ack_i <= 1'b0;
      slot_rdata_i <= '0;
      lat_cnt <= 0;
    end else if (seen_arm != arm_id) begin
      seen_arm <= arm_id;
      given <= 0;
      rd_idx <= 0;
      lat_cnt <= 0;
      slot_ack_i <= 1'b0;
    end else if (slot_ack_i) begin
      slot_ack_i <= 1'b0;
    end else if (slot_req_o && given < ack_budget) begin
      if (lat_cnt == LAT) begin
        slot_ack_i <= 1'b1;
        lat_cnt <= 0;
        given <= given + 1;
        if (!slot_wr_o) begin
          slot_rdata_i <= (rd_idx == 0) ? rd_word0 : rd_word1;
          rd_idx <= rd_idx + 1;
        end else slot_rdata_i <= 8'hA5;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_arm != arm_id) begin
      mon_arm = arm_id;
      req_cyc = 0; xfers = 0; writes = 0; done_cyc = 0; rd_seen = 0;
      order_ok = 2'b11;
    end
    if (slot_req_o) req_cyc++;
    if (done_o) done_cyc++;
    if (slot_req_o && slot_ack_i) begin
      xfers++;
      if (slot_wr_o) begin
        writes++;
        last_wbit = slot_wbit_o;
        if (rd_seen != 2) order_ok = 2'b00;
      end else begin
        rd_seen++;
        if (writes != 0) order_ok = 2'b00;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one step; extra_start pulses start with the opposite preference while busy
  task automatic run_step(input logic [RW-1:0] w0, input logic [RW-1:0] w1,
                          input logic pref, input int budget, input logic extra_start);
    @(posedge clk); #1;
    rd_word0 = w0; rd_word1 = w1; ack_budget = budget;
    arm_id = arm_id + 1;
    @(negedge clk);
    start_i = 1'b1; dir_pref_i = pref;
    @(negedge clk);
    start_i = 1'b0;
    if (extra_start) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1; dir_pref_i = ~pref;
      repeat (3) @(negedge clk);
      start_i = 1'b0; dir_pref_i = pref;
    end
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk);
    check(done_o, "R10 done seen", done_o, 1);
    @(negedge clk);
    check(!busy_o && !done_o, "R10 idle after done", busy_o, 0);
    check(done_cyc == 1, "R10 done width", done_cyc, 1);
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o && !slot_req_o && !slot_wr_o && !err_o,
          "R1 idle outputs", {busy_o, done_o, slot_req_o, slot_wr_o, err_o}, 0);
    check(result_o == 3'b000, "R1 result", result_o, 0);
  endtask

  task automatic t_nobody;
    run_step(8'h01, 8'h01, 1'b1, 3, 1'b0);
    check(result_o == 3'b011, "R3 result", result_o, 3);
    check(writes == 0, "R3 no write", writes, 0);
    check(req_cyc == 2 * SLOT, "R3 req cycles", req_cyc, 2 * SLOT);
    check(!err_o, "R3 no err", err_o, 0);
  endtask

  task automatic t_conflict(input logic pref);
    run_step(8'h00, 8'h00, pref, 3, 1'b0);
    check(result_o == (pref ? 3'b100 : 3'b000), "R4 result", result_o, pref ? 4 : 0);
    check(writes == 1 && last_wbit == pref, "R7 written bit", last_wbit, pref);
    check(req_cyc == 3 * SLOT, "R2 req cycles", req_cyc, 3 * SLOT);
    check(order_ok == 2'b11 && xfers == 3, "R2 order", xfers, 3);
  endtask

  task automatic t_forced(input logic abit);
    run_step({7'h00, abit}, {7'h00, ~abit}, ~abit, 3, 1'b0);
    check(result_o == (abit ? 3'b101 : 3'b010), "R5 result", result_o, abit ? 5 : 2);
    check(writes == 1 && last_wbit == abit, "R7 forced bit", last_wbit, abit);
    check(result_o[2] == last_wbit, "R7 bit2 equals write", result_o[2], last_wbit);
  endtask

  task automatic t_upper_bits;
    run_step(8'hFE, 8'hFE, 1'b1, 3, 1'b0);
    check(result_o == 3'b100, "R6 zeros with junk", result_o, 4);
    run_step(8'h01, 8'hFE, 1'b0, 3, 1'b0);
    check(result_o == 3'b101, "R6 one with junk", result_o, 5);
  endtask

  task automatic t_busy_start;
    run_step(8'h00, 8'h00, 1'b0, 3, 1'b1);
    check(result_o == 3'b000 && last_wbit == 1'b0, "R9 pref kept", result_o, 0);
    check(xfers == 3, "R9 one step only", xfers, 3);
    repeat (10) @(negedge clk);
    check(!busy_o && req_cyc == 3 * SLOT, "R9 no restart", req_cyc, 3 * SLOT);
  endtask

  task automatic t_timeout(input int budget);
    run_step(8'h00, 8'h00, 1'b1, budget, 1'b0);
    check(result_o == 3'b011, "R8 result", result_o, 3);
    check(err_o, "R8 err", err_o, 1);
    check(xfers == budget, "R8 transfers", xfers, budget);
    if (budget == 0) check(req_cyc == AW, "R8 window", req_cyc, AW);
    if (budget < 3) check(writes == 0, "R8 no write", writes, 0);
  endtask

  task automatic t_err_clear;
    run_step(8'h00, 8'h01, 1'b1, 3, 1'b0);
    check(!err_o, "R11 err cleared", err_o, 0);
    check(result_o == 3'b010, "R11 result", result_o, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nobody();
    t_conflict(1'b1);
    t_conflict(1'b0);
    t_forced(1'b1);
    t_forced(1'b0);
    t_upper_bits();
    t_busy_start();
    t_timeout(0);
    t_timeout(1);
    t_timeout(2);
    t_err_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule